// File: doc/BRIEF.md
# Linked-List Descriptor Loader

This block sits beside one DMA channel and feeds it from a chain of transfer descriptors stored in memory. Software programs a list-control register and the head descriptor address, then pulses the channel enable. The loader reads each descriptor one 32-bit word at a time and copies its fields into the channel transfer registers. It then starts the data mover through a start/done handshake and follows the link word to the next descriptor.

A descriptor header describes the node that follows it: its type, whether it carries a source and a destination address, and whether its completion must be signalled. From these the loader knows how many words to read for the next node and which registers they update. Registers that a node does not carry keep their earlier values. The walk stops at the end-of-list marker, at a node whose pause flag is set, or at an unsupported type code.

Top module: `lld_loader`

## Requirements
- R1: After reset no read or transfer is issued, the control readback, the completed-node count and the error flag are zero.
- R2: A channel enable while control bit 8 (list mode) is clear has no effect: no descriptor read and no transfer start follow it.
- R3: With control bit 10 (fast mode) set, the head descriptor is read and loaded before the first transfer starts, so the first transfer uses the head's fields.
- R4: With fast mode clear, the first transfer runs on the registers as already programmed, and the head descriptor is read only after that transfer completes.
- R5: A node is read as word 0 (link), word 1 (header), then the source address if flagged valid, then the destination address if flagged valid, then 8 config words for type 1, 4 for type 2 and none for type 3. An address not flagged valid leaves its register unchanged, and so do config words that the type omits.
- R6: Header word bits 31:29 give the next node's type (1, 2 or 3), bit 24 flags its source address valid, bit 26 flags its destination address valid, and bits 23:0 load the element count. Config word 0 bits 15:0 form the frame count.
- R7: A link word of 0xFFFFFFFC ends the list: after that node completes nothing more is read and one list-done pulse is emitted.
- R8: Link word bit 0 set pauses the walk after that node completes and sets control bit 7. Enables are ignored while bit 7 is set. Writing bit 7 to zero and enabling again resumes at the following node.
- R9: The completed-node count rises by one per finished descriptor. The transfer run before the head in normal mode is not counted. Writing the head address clears the count.
- R10: Header bit 28 marks the next node for block-end notification, and a one-cycle block-end pulse follows that node's completion.
- R11: A next-node type code of 0 or above 3 stops the walk and sets a sticky error flag. Enables are ignored while the flag is set, and writing the head address clears it.
- R12: Writing the head address presets the frame count to 0xFFFF and the element count to 0xFFFFFF.
- R13: For the head node, control bits 5:4 give the type, bit 2 flags its source address valid and bit 0 flags its destination address valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_wr_i | input | 1 | Write strobe for the list-control register |
| ctrl_wdata_i | input | 16 | List-control write data |
| ndp_wr_i | input | 1 | Write strobe for the head descriptor address |
| ndp_wdata_i | input | 32 | Head descriptor byte address |
| chan_en_i | input | 1 | Channel enable pulse |
| ctrl_o | output | 16 | List-control readback, including the paused bit |
| rd_req_o | output | 1 | Descriptor word read request, one cycle |
| rd_addr_o | output | 32 | Byte address of the requested word |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | 32 | Read data |
| xfer_start_o | output | 1 | Start pulse to the data mover |
| xfer_done_i | input | 1 | Data mover completion pulse |
| src_addr_o | output | 32 | Source address register |
| dst_addr_o | output | 32 | Destination address register |
| elem_cnt_o | output | 24 | Element count register |
| frame_cnt_o | output | 16 | Frame count (low half of config word 0) |
| cfg_regs_o | output | 256 | Eight config words, word k at bits 32k+31:32k |
| node_cnt_o | output | 16 | Completed-node count |
| blk_end_o | output | 1 | Block-end notification pulse |
| list_done_o | output | 1 | End-of-list pulse |
| desc_err_o | output | 1 | Sticky descriptor type error |

## Verification
A wrong fetch index or slot decode shows up on the next transfer start. The registers seen at that start hold a word from the wrong slot, and the number of reads for the node differs from the count that the type and valid flags imply. Corrupted next-node state, such as the type, the flags or the link, becomes visible only one node later: an extra or missing read, a wrong retained address, a misplaced block-end pulse, or a premature list-done or error. The directed scenarios therefore use chains of at least three nodes of mixed types, so that every carried-over flag reaches a transfer before the bench checks the result.

// File: rtl/lld_pkg.sv
package lld_pkg;
  localparam int unsigned CTRL_W = 16;
  localparam logic [31:0] END_MARK = 32'hFFFF_FFFC;
  // control register bits
  localparam int unsigned CB_DSTV   = 0;
  localparam int unsigned CB_SRCV   = 2;
  localparam int unsigned CB_TLO    = 4;
  localparam int unsigned CB_PAUSED = 7;
  localparam int unsigned CB_LIST   = 8;
  localparam int unsigned CB_FAST   = 10;
  // header word bits
  localparam int unsigned HB_SRCV = 24;
  localparam int unsigned HB_DSTV = 26;
  localparam int unsigned HB_BLK  = 28;
  localparam int unsigned HB_TLO  = 29;

  typedef enum logic [2:0] {ST_IDLE, ST_FREQ, ST_FWAIT, ST_XSTART, ST_XWAIT, ST_ADV} st_e;
  typedef enum logic [2:0] {FLD_LINK, FLD_HDR, FLD_SRC, FLD_DST, FLD_CFG} fld_e;
endpackage

// File: rtl/lld_slot_map.sv
module lld_slot_map
  import lld_pkg::*;
#(
  parameter int unsigned NCFG  = 8,
  parameter int unsigned IDX_W = 4
) (
  input  logic [1:0]       typ_i,
  input  logic             srcv_i,
  input  logic             dstv_i,
  input  logic [IDX_W-1:0] idx_i,
  output fld_e             fld_o,
  output logic [IDX_W-1:0] cfg_k_o,
  output logic             last_o
);
  localparam int unsigned HALF = NCFG / 2;

  logic [IDX_W-1:0] n_cfg, n_words, j, j2;

  always_comb begin
    n_cfg   = (typ_i == 2'd1) ? IDX_W'(NCFG) : (typ_i == 2'd2) ? IDX_W'(HALF) : '0;
    n_words = IDX_W'(2) + IDX_W'(srcv_i) + IDX_W'(dstv_i) + n_cfg;
    j       = idx_i - IDX_W'(2);
    j2      = j - IDX_W'(srcv_i);
    cfg_k_o = j2 - IDX_W'(dstv_i);
    last_o  = (idx_i == n_words - IDX_W'(1));
    if (idx_i == '0)                    fld_o = FLD_LINK;
    else if (idx_i == IDX_W'(1))        fld_o = FLD_HDR;
    else if (srcv_i && (j == '0))       fld_o = FLD_SRC;
    else if (dstv_i && (j2 == '0))      fld_o = FLD_DST;
    else                                fld_o = FLD_CFG;
  end
endmodule

// File: rtl/lld_node_cnt.sv
module lld_node_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (inc_i)  cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/lld_loader.sv
module lld_loader
  import lld_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned NCFG   = 8,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ELEM_W = 24,
  parameter int unsigned FRM_W  = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ctrl_wr_i,
  input  logic [CTRL_W-1:0]   ctrl_wdata_i,
  input  logic                ndp_wr_i,
  input  logic [DW-1:0]       ndp_wdata_i,
  input  logic                chan_en_i,
  output logic [CTRL_W-1:0]   ctrl_o,
  output logic                rd_req_o,
  output logic [DW-1:0]       rd_addr_o,
  input  logic                rd_valid_i,
  input  logic [DW-1:0]       rd_data_i,
  output logic                xfer_start_o,
  input  logic                xfer_done_i,
  output logic [DW-1:0]       src_addr_o,
  output logic [DW-1:0]       dst_addr_o,
  output logic [ELEM_W-1:0]   elem_cnt_o,
  output logic [FRM_W-1:0]    frame_cnt_o,
  output logic [NCFG*DW-1:0]  cfg_regs_o,
  output logic [CNT_W-1:0]    node_cnt_o,
  output logic                blk_end_o,
  output logic                list_done_o,
  output logic                desc_err_o
);
  localparam int unsigned IDX_W = $clog2(NCFG + 5);

  st_e              st_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DW-1:0]    ndp_q, base_q, nxt_ptr_q, src_q, dst_q;
  logic [DW-1:0]    cfg_q [NCFG];
  logic [ELEM_W-1:0] elem_q;
  logic [IDX_W-1:0] idx_q;
  logic [2:0]       nxt_type_q;
  logic             nxt_srcv_q, nxt_dstv_q, nxt_blk_q;
  logic [1:0]       cur_type_q;
  logic             cur_srcv_q, cur_dstv_q, cur_blk_q, cur_pause_q;
  logic             pre_run_q, resume_q, err_q, blk_q, done_q;

  fld_e             fld;
  logic [IDX_W-1:0] cfg_k;
  logic             last;
  logic             node_fin, nxt_type_ok;

  lld_slot_map #(.NCFG(NCFG), .IDX_W(IDX_W)) u_map (
    .typ_i(cur_type_q), .srcv_i(cur_srcv_q), .dstv_i(cur_dstv_q),
    .idx_i(idx_q), .fld_o(fld), .cfg_k_o(cfg_k), .last_o(last)
  );

  assign node_fin = (st_q == ST_XWAIT) && xfer_done_i && !pre_run_q;

  lld_node_cnt #(.W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(ndp_wr_i), .inc_i(node_fin), .cnt_o(node_cnt_o)
  );

  assign nxt_type_ok = (nxt_type_q != 3'd0) && (nxt_type_q <= 3'd3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;   ctrl_q <= '0;   ndp_q <= '0;   base_q <= '0;
      nxt_ptr_q <= '0;   src_q <= '0;    dst_q <= '0;   elem_q <= '0;
      for (int k = 0; k < NCFG; k++) cfg_q[k] <= '0;
      idx_q <= '0;       nxt_type_q <= '0; nxt_srcv_q <= 1'b0; nxt_dstv_q <= 1'b0;
      nxt_blk_q <= 1'b0; cur_type_q <= '0; cur_srcv_q <= 1'b0; cur_dstv_q <= 1'b0;
      cur_blk_q <= 1'b0; cur_pause_q <= 1'b0; pre_run_q <= 1'b0; resume_q <= 1'b0;
      err_q <= 1'b0;     blk_q <= 1'b0;   done_q <= 1'b0;
    end else begin
      blk_q  <= 1'b0;
      done_q <= 1'b0;
      if (ctrl_wr_i) begin
        ctrl_q <= ctrl_wdata_i;
        ctrl_q[CB_PAUSED] <= ctrl_q[CB_PAUSED] & ctrl_wdata_i[CB_PAUSED]; // clear-only
      end
      if (ndp_wr_i) begin
        ndp_q    <= ndp_wdata_i;
        elem_q   <= '1;
        cfg_q[0][FRM_W-1:0] <= '1;
        err_q    <= 1'b0;
        resume_q <= 1'b0;
      end
      unique case (st_q)
        ST_IDLE: if (chan_en_i && ctrl_q[CB_LIST] && !ctrl_q[CB_PAUSED] && !err_q) begin
          if (resume_q) begin
            resume_q <= 1'b0;
            st_q     <= ST_ADV;
          end else begin
            nxt_type_q <= {1'b0, ctrl_q[CB_TLO+1:CB_TLO]};
            nxt_srcv_q <= ctrl_q[CB_SRCV];
            nxt_dstv_q <= ctrl_q[CB_DSTV];
            nxt_blk_q  <= 1'b0;
            nxt_ptr_q  <= ndp_q;
            if (ctrl_q[CB_FAST]) st_q <= ST_ADV;
            else begin
              pre_run_q <= 1'b1;
              st_q      <= ST_XSTART;
            end
          end
        end
        ST_ADV: begin
          if (nxt_ptr_q == END_MARK) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else if (!nxt_type_ok) begin
            err_q <= 1'b1;
            st_q  <= ST_IDLE;
          end else begin
            cur_type_q <= nxt_type_q[1:0];
            cur_srcv_q <= nxt_srcv_q;
            cur_dstv_q <= nxt_dstv_q;
            cur_blk_q  <= nxt_blk_q;
            base_q     <= nxt_ptr_q;
            idx_q      <= '0;
            st_q       <= ST_FREQ;
          end
        end
        ST_FREQ: st_q <= ST_FWAIT;
        ST_FWAIT: if (rd_valid_i) begin
          unique case (fld)
            FLD_LINK: begin
              nxt_ptr_q   <= {rd_data_i[DW-1:2], 2'b00};
              cur_pause_q <= rd_data_i[0];
            end
            FLD_HDR: begin
              elem_q     <= rd_data_i[ELEM_W-1:0];
              nxt_type_q <= rd_data_i[HB_TLO+2:HB_TLO];
              nxt_srcv_q <= rd_data_i[HB_SRCV];
              nxt_dstv_q <= rd_data_i[HB_DSTV];
              nxt_blk_q  <= rd_data_i[HB_BLK];
            end
            FLD_SRC: src_q <= rd_data_i;
            FLD_DST: dst_q <= rd_data_i;
            default: for (int k = 0; k < NCFG; k++)
              if (cfg_k == IDX_W'(k)) cfg_q[k] <= rd_data_i;
          endcase
          if (last) st_q <= ST_XSTART;
          else begin
            idx_q <= idx_q + IDX_W'(1);
            st_q  <= ST_FREQ;
          end
        end
        ST_XSTART: st_q <= ST_XWAIT;
        ST_XWAIT: if (xfer_done_i) begin
          if (pre_run_q) begin
            pre_run_q <= 1'b0;
            st_q      <= ST_ADV;
          end else begin
            blk_q <= cur_blk_q;
            if (cur_pause_q) begin
              ctrl_q[CB_PAUSED] <= 1'b1;
              resume_q          <= 1'b1;
              st_q              <= ST_IDLE;
            end else st_q <= ST_ADV;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ctrl_o       = ctrl_q;
  assign rd_req_o     = (st_q == ST_FREQ);
  assign rd_addr_o    = base_q + DW'({idx_q, 2'b00});
  assign xfer_start_o = (st_q == ST_XSTART);
  assign src_addr_o   = src_q;
  assign dst_addr_o   = dst_q;
  assign elem_cnt_o   = elem_q;
  assign frame_cnt_o  = cfg_q[0][FRM_W-1:0];
  assign blk_end_o    = blk_q;
  assign list_done_o  = done_q;
  assign desc_err_o   = err_q;

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    assign cfg_regs_o[g*DW +: DW] = cfg_q[g];
  end
endmodule

// File: rtl/lld_loader_chk.sv
module lld_loader_chk #(
  parameter int unsigned CTRL_W = 16,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ndp_wr_i,
  input logic [CTRL_W-1:0] ctrl_o,
  input logic              rd_req_o,
  input logic              xfer_start_o,
  input logic              list_done_o,
  input logic              desc_err_o,
  input logic [CNT_W-1:0]  node_cnt_o
);
  // one outstanding read: a request is a single-cycle pulse
  assert_rd_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    list_done_o |=> !list_done_o);

  assert_paused_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[7] |-> (!rd_req_o && !xfer_start_o));

  assert_cnt_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((node_cnt_o != $past(node_cnt_o)) && !$past(ndp_wr_i))
      |-> (node_cnt_o == CNT_W'($past(node_cnt_o) + 1'b1)));

  assert_err_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_err_o && !ndp_wr_i) |=> desc_err_o);

  assert_err_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_err_o |-> (!rd_req_o && !xfer_start_o));
endmodule

bind lld_loader lld_loader_chk #(.CTRL_W(lld_pkg::CTRL_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ndp_wr_i(ndp_wr_i), .ctrl_o(ctrl_o),
  .rd_req_o(rd_req_o), .xfer_start_o(xfer_start_o), .list_done_o(list_done_o),
  .desc_err_o(desc_err_o), .node_cnt_o(node_cnt_o)
);

// File: tb/lld_loader_test.sv
`timescale 1ns/1ps
module lld_loader_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  logic        ctrl_wr = 0, ndp_wr = 0, chan_en = 0;
  logic [15:0] ctrl_wdata = '0;
  logic [31:0] ndp_wdata = '0;
  logic [15:0] ctrl_rb;
  logic        rd_req, rd_valid, xfer_start, xfer_done;
  logic [31:0] rd_addr, rd_data, src_a, dst_a;
  logic [23:0] elem_c;
  logic [15:0] frame_c, node_c;
  logic [255:0] cfg_r;
  logic        blk_end, list_done, desc_err;

  lld_loader uut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_wr_i(ctrl_wr), .ctrl_wdata_i(ctrl_wdata),
    .ndp_wr_i(ndp_wr), .ndp_wdata_i(ndp_wdata), .chan_en_i(chan_en), .ctrl_o(ctrl_rb),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_valid_i(rd_valid), .rd_data_i(rd_data),
    .xfer_start_o(xfer_start), .xfer_done_i(xfer_done), .src_addr_o(src_a),
    .dst_addr_o(dst_a), .elem_cnt_o(elem_c), .frame_cnt_o(frame_c), .cfg_regs_o(cfg_r),
    .node_cnt_o(node_c), .blk_end_o(blk_end), .list_done_o(list_done), .desc_err_o(desc_err)
  );

  logic [31:0] mem [256];
  int n_rd = 0, n_x = 0, n_blk = 0, n_done = 0;
  logic [31:0] lg_src [32], lg_dst [32];
  logic [23:0] lg_elem [32];
  logic [15:0] lg_frm [32];
  logic [2:0]  mcnt = '0;
  int errors = 0, checks = 0;
  bit finished = 0;

  // memory responder, data mover and event log
  always @(posedge clk) begin
    rd_valid  <= rd_req;
    rd_data   <= mem[rd_addr[9:2]];
    xfer_done <= (mcnt == 3'd1);
    if (xfer_start) mcnt <= 3'd3;
    else if (mcnt != 0) mcnt <= mcnt - 3'd1;
    if (rd_req) n_rd <= n_rd + 1;
    if (xfer_start) begin
      lg_src[n_x[4:0]]  <= src_a;
      lg_dst[n_x[4:0]]  <= dst_a;
      lg_elem[n_x[4:0]] <= elem_c;
      lg_frm[n_x[4:0]]  <= frame_c;
      n_x <= n_x + 1;
    end
    if (blk_end) n_blk <= n_blk + 1;
    if (list_done) n_done <= n_done + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr(input int t, input bit s, input bit d, input bit b, input int e);
    return (32'(t) << 29) | (32'(b) << 28) | (32'(d) << 26) | (32'(s) << 24) | (32'(e) & 32'hFF_FFFF);
  endfunction

  task automatic wr_ctrl(input logic [15:0] v);
    @(negedge clk); ctrl_wr = 1; ctrl_wdata = v; @(negedge clk); ctrl_wr = 0;
  endtask
  task automatic wr_ndp(input logic [31:0] v);
    @(negedge clk); ndp_wr = 1; ndp_wdata = v; @(negedge clk); ndp_wr = 0;
  endtask
  task automatic enable();
    @(negedge clk); chan_en = 1; @(negedge clk); chan_en = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  localparam logic [15:0] FAST_T1 = 16'h0400 | 16'h0100 | 16'h0010 | 16'h0005;

  // three-node chain: type1 @0x40, type2b @0x100, type3a @0x180
  task automatic build_chain();
    mem[16] = 32'h100;
    mem[17] = hdr(2, 1, 0, 1, 10);
    mem[18] = 32'hA000; mem[19] = 32'hB000;
    for (int k = 0; k < 8; k++) mem[20+k] = 32'h1000 + k;
    mem[64] = 32'h180;
    mem[65] = hdr(3, 1, 1, 0, 20);
    mem[66] = 32'hA100;
    for (int k = 0; k < 4; k++) mem[67+k] = 32'h2000 + k;
    mem[96] = 32'hFFFF_FFFC;
    mem[97] = hdr(0, 0, 0, 0, 30);
    mem[98] = 32'hA200; mem[99] = 32'hB200;
  endtask

  task automatic t_reset();
    chk("R1 ctrl", 32'(ctrl_rb), 0);
    chk("R1 node_cnt", 32'(node_c), 0);
    chk("R1 err", 32'(desc_err), 0);
    chk("R1 rd_req", 32'(rd_req), 0);
    chk("R1 xfer_start", 32'(xfer_start), 0);
  endtask

  task automatic t_no_list();
    int r0 = n_rd, x0 = n_x;
    wr_ctrl(16'h0415); wr_ndp(32'h40); enable(); idle(30);
    chk("R2 reads", n_rd - r0, 0);
    chk("R2 xfers", n_x - x0, 0);
  endtask

  task automatic t_fast();
    int r0 = n_rd, x0 = n_x, b0 = n_blk, d0 = n_done;
    wr_ctrl(FAST_T1); wr_ndp(32'h40); enable(); idle(200);
    chk("R5 reads", n_rd - r0, 23);
    chk("R3 xfers", n_x - x0, 3);
    chk("R3 R13 head src", lg_src[x0], 32'hA000);
    chk("R13 head dst", lg_dst[x0], 32'hB000);
    chk("R6 head elem", 32'(lg_elem[x0]), 10);
    chk("R6 head frame", 32'(lg_frm[x0]), 32'h1000);
    chk("R5 n2 src", lg_src[x0+1], 32'hA100);
    chk("R5 n2 dst kept", lg_dst[x0+1], 32'hB000);
    chk("R6 n2 frame", 32'(lg_frm[x0+1]), 32'h2000);
    chk("R6 n3 src", lg_src[x0+2], 32'hA200);
    chk("R6 n3 dst", lg_dst[x0+2], 32'hB200);
    chk("R6 n3 elem", 32'(lg_elem[x0+2]), 30);
    chk("R5 cfg4 kept", cfg_r[4*32 +: 32], 32'h1004);
    chk("R5 cfg3 from n2", cfg_r[3*32 +: 32], 32'h2003);
    chk("R9 node_cnt", 32'(node_c), 3);
    chk("R10 blk pulses", n_blk - b0, 1);
    chk("R7 list_done", n_done - d0, 1);
  endtask

  task automatic t_normal();
    int r0, x0;
    wr_ctrl(16'h0135); wr_ndp(32'h180);
    chk("R12 elem preset", 32'(elem_c), 32'hFF_FFFF);
    chk("R12 frame preset", 32'(frame_c), 32'hFFFF);
    chk("R9 cnt cleared", 32'(node_c), 0);
    r0 = n_rd; x0 = n_x;
    enable(); idle(4);
    chk("R4 no early read", n_rd - r0, 0);
    idle(60);
    chk("R4 xfers", n_x - x0, 2);
    chk("R4 first uses preset", 32'(lg_elem[x0]), 32'hFF_FFFF);
    chk("R4 second uses head", 32'(lg_elem[x0+1]), 30);
    chk("R4 reads", n_rd - r0, 4);
    chk("R9 pre-run not counted", 32'(node_c), 1);
  endtask

  task automatic t_pause();
    int r0, x0, d0;
    mem[16] = 32'h101;
    wr_ctrl(FAST_T1); wr_ndp(32'h40);
    r0 = n_rd; x0 = n_x; d0 = n_done;
    enable(); idle(100);
    chk("R8 paused bit", 32'(ctrl_rb[7]), 1);
    chk("R8 one xfer", n_x - x0, 1);
    chk("R8 reads", n_rd - r0, 12);
    chk("R8 cnt", 32'(node_c), 1);
    enable(); idle(40);
    chk("R8 enable ignored while paused", n_rd - r0, 12);
    wr_ctrl(FAST_T1); enable(); idle(150);
    chk("R8 resumed xfers", n_x - x0, 3);
    chk("R8 resumed reads", n_rd - r0, 23);
    chk("R8 cleared", 32'(ctrl_rb[7]), 0);
    chk("R7 done after resume", n_done - d0, 1);
    chk("R9 cnt after resume", 32'(node_c), 3);
    mem[16] = 32'h100;
  endtask

  task automatic t_err();
    int r0, x0, d0;
    mem[17] = hdr(5, 1, 0, 1, 10);
    wr_ctrl(FAST_T1); wr_ndp(32'h40);
    r0 = n_rd; x0 = n_x; d0 = n_done;
    enable(); idle(100);
    chk("R11 err set", 32'(desc_err), 1);
    chk("R11 one xfer", n_x - x0, 1);
    chk("R11 no further reads", n_rd - r0, 12);
    chk("R11 no done", n_done - d0, 0);
    enable(); idle(40);
    chk("R11 enable ignored", n_rd - r0, 12);
    chk("R11 sticky", 32'(desc_err), 1);
    wr_ndp(32'h40);
    chk("R11 cleared by head write", 32'(desc_err), 0);
    mem[17] = hdr(0, 1, 0, 1, 10);
    r0 = n_rd;
    enable(); idle(100);
    chk("R11 type 0 err", 32'(desc_err), 1);
    chk("R11 type 0 reads", n_rd - r0, 12);
    mem[17] = hdr(2, 1, 0, 1, 10);
  endtask

  initial begin
    for (int k = 0; k < 256; k++) mem[k] = '0;
    build_chain();
    idle(3);
    t_reset();
    @(negedge clk); rst_n = 1;
    idle(2);
    t_reset();
    t_no_list();
    t_fast();
    t_normal();
    t_pause();
    t_err();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule